// File: doc/BRIEF.md
# Linked Command Descriptor Walker

This block runs a chain of command descriptors kept in a halfword-wide memory. A start strobe hands it the byte address of the first descriptor. For each descriptor it marks the status halfword busy and fetches the command halfword. It then presents the 3-bit opcode to an external handler and waits for that handler to finish. When the handler is done, the block writes a completed-OK status and fetches the 32-bit link to the next descriptor. Memory traffic uses a request/acknowledge port that carries one halfword per transfer.

Three control bits in each command halfword steer the walk. One ends the list. One parks the unit in a suspended state. One raises a command-complete flag. A link of all ones also ends the walk. After each descriptor a one-cycle completion event fires, and the unit state shows whether the walk is idle, suspended or still active. The unit state is encoded as idle = 0, suspended = 1, active = 2.

Descriptor layout, with byte offsets from the descriptor address: the status halfword is at +0, the command halfword at +2, the low half of the link at +4 and the high half of the link at +6.

Top module: `cmd_walker`

## Requirements
- R1: After reset, cuState is idle (0), cxFlag is 0, and memReq, opValid and cmdDone are all low.
- R2: A start strobe whose pointer is not 0xFFFFFFFF makes cuState active (2) from the next cycle, provided the unit is idle or suspended. A start whose pointer is 0xFFFFFFFF leaves the unit idle and issues no memory access. A start received while the unit is active has no effect on the walk.
- R3: Before dispatch, the block writes 0x4000 (busy) to the status halfword at +0 and then reads the command halfword at +2.
- R4: opValid presents opCode = command bits 2:0 and opPtr = the descriptor address, and stays high until opDone. Every one of the eight opcodes completes.
- R5: After opDone, the block writes 0xA000 (complete and OK) to the status halfword at +0.
- R6: Command bit 15 (end of list) ends the walk after its descriptor without reading the link. The unit becomes idle unless R8 applies.
- R7: The link is read low halfword at +4, then high halfword at +6. A link of 0xFFFFFFFF ends the walk with the unit idle. Any other link is walked next.
- R8: Command bit 14 (suspend) leaves the unit suspended (1) after its descriptor, even when the descriptor also ends the walk.
- R9: cmdDone pulses for exactly one cycle per finished descriptor. cxFlag then takes the value of command bit 13 of that descriptor.
- R10: memReq, once raised, stays high with a stable memAddr, memWe and memWdata until memAck. memReq and opValid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start strobe |
| startPtr | input | 32 | Byte address of the first descriptor |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the halfword |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Transfer complete |
| opValid | output | 1 | Opcode offered to the handler |
| opCode | output | 3 | Opcode field of the command |
| opPtr | output | 32 | Address of the current descriptor |
| opDone | input | 1 | Handler finished |
| cmdDone | output | 1 | One-cycle completion event per descriptor |
| cxFlag | output | 1 | Command-complete interrupt flag |
| cuState | output | 2 | 0 idle, 1 suspended, 2 active |

## Verification
End of list and suspend can sit in the same command halfword, and so can either of them together with the interrupt bit. The finish step then has to resolve the end of the walk, the suspended state and the flag in a single cycle. The bench sweeps all eight opcodes against all eight combinations of the three control bits, using a two-descriptor chain each time. From the bits it computes how many descriptors run, how many memory transfers happen, the final state, the flag value and both status halfwords. Suspend must win over end of list, and the flag must follow the last descriptor that actually ran.

// File: rtl/cmd_walker_pkg.sv
package cmd_walker_pkg;
  parameter int HW_W = 16;
  localparam int PTR_W = 2 * HW_W;
  localparam int HW_BYTES = HW_W / 8;
  localparam int OP_W = 3;
  localparam int BIT_EOL = 15;
  localparam int BIT_SUSP = 14;
  localparam int BIT_INTR = 13;
  localparam logic [HW_W-1:0] STAT_BUSY = HW_W'(1) << 14;
  localparam logic [HW_W-1:0] STAT_DONE = (HW_W'(1) << 15) | (HW_W'(1) << 13);

  typedef enum logic [1:0] {CU_IDLE = 2'd0, CU_SUSP = 2'd1, CU_ACTIVE = 2'd2} cuState_e;
  typedef enum logic [1:0] {OFS_STAT = 2'd0, OFS_CMD = 2'd1, OFS_LLO = 2'd2, OFS_LHI = 2'd3} ofs_e;

  typedef struct packed {
    logic loadStart;
    logic loadCmd;
    logic loadLinkLo;
    logic loadLinkHi;
    logic setNull;
    logic wrDone;
    ofs_e ofs;
  } dpCtl_t;
endpackage

// File: rtl/cmd_walker_dp.sv
module cmd_walker_dp
  import cmd_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [PTR_W-1:0]  startPtr,
  input  logic [HW_W-1:0]   memRdata,
  output logic [PTR_W-1:0]  memAddr,
  output logic [HW_W-1:0]   memWdata,
  output logic [PTR_W-1:0]  curPtr,
  output logic [OP_W-1:0]   opCode,
  output logic              cmdEol,
  output logic              cmdSusp,
  output logic              cmdIntr,
  output logic              ptrNull,
  output logic              startNull
);
  logic [HW_W-1:0] cmdReg;
  logic [HW_W-1:0] linkLo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPtr <= '1;
      cmdReg <= '0;
      linkLo <= '0;
    end else begin
      if (ctl.loadStart) curPtr <= startPtr;
      if (ctl.loadCmd) cmdReg <= memRdata;
      if (ctl.loadLinkLo) linkLo <= memRdata;
      if (ctl.loadLinkHi) curPtr <= {memRdata, linkLo};
      if (ctl.setNull) curPtr <= '1;
    end
  end

  always_comb begin
    memAddr = curPtr + PTR_W'(32'(ctl.ofs) * HW_BYTES);
    memWdata = ctl.wrDone ? STAT_DONE : STAT_BUSY;
  end

  assign opCode = cmdReg[OP_W-1:0];
  assign cmdEol = cmdReg[BIT_EOL];
  assign cmdSusp = cmdReg[BIT_SUSP];
  assign cmdIntr = cmdReg[BIT_INTR];
  assign ptrNull = &curPtr;
  assign startNull = &startPtr;
endmodule

// File: rtl/cmd_walker_ctrl.sv
module cmd_walker_ctrl
  import cmd_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startValid,
  input  logic     startNull,
  input  logic     memAck,
  input  logic     opDone,
  input  logic     cmdEol,
  input  logic     cmdSusp,
  input  logic     cmdIntr,
  input  logic     ptrNull,
  output dpCtl_t   ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     opValid,
  output logic     cmdDone,
  output logic     cxFlag,
  output cuState_e cuState
);
  typedef enum logic [2:0] {
    S_WAIT, S_MARK, S_FETCH, S_EXEC, S_CLOSE, S_LINKLO, S_LINKHI, S_WRAP
  } walk_e;

  walk_e state, stateNext;
  cuState_e cuNext;
  logic cxNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cuState <= CU_IDLE;
      cxFlag <= 1'b0;
    end else begin
      state <= stateNext;
      cuState <= cuNext;
      cxFlag <= cxNext;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.ofs = OFS_STAT;
    stateNext = state;
    cuNext = cuState;
    cxNext = cxFlag;
    memReq = 1'b0;
    memWe = 1'b0;
    opValid = 1'b0;
    cmdDone = 1'b0;
    unique case (state)
      S_WAIT: begin
        if (startValid && !startNull) begin
          ctl.loadStart = 1'b1;
          cuNext = CU_ACTIVE;
          stateNext = S_MARK;
        end
      end
      S_MARK: begin
        memReq = 1'b1;
        memWe = 1'b1;
        if (memAck) stateNext = S_FETCH;
      end
      S_FETCH: begin
        memReq = 1'b1;
        ctl.ofs = OFS_CMD;
        if (memAck) begin
          ctl.loadCmd = 1'b1;
          stateNext = S_EXEC;
        end
      end
      S_EXEC: begin
        opValid = 1'b1;
        if (opDone) stateNext = S_CLOSE;
      end
      S_CLOSE: begin
        memReq = 1'b1;
        memWe = 1'b1;
        ctl.wrDone = 1'b1;
        if (memAck) begin
          if (cmdEol) begin
            ctl.setNull = 1'b1;
            stateNext = S_WRAP;
          end else begin
            stateNext = S_LINKLO;
          end
        end
      end
      S_LINKLO: begin
        memReq = 1'b1;
        ctl.ofs = OFS_LLO;
        if (memAck) begin
          ctl.loadLinkLo = 1'b1;
          stateNext = S_LINKHI;
        end
      end
      S_LINKHI: begin
        memReq = 1'b1;
        ctl.ofs = OFS_LHI;
        if (memAck) begin
          ctl.loadLinkHi = 1'b1;
          stateNext = S_WRAP;
        end
      end
      S_WRAP: begin
        cmdDone = 1'b1;
        cxNext = cmdIntr;
        if (cmdSusp) begin
          cuNext = CU_SUSP;
          stateNext = S_WAIT;
        end else if (ptrNull) begin
          cuNext = CU_IDLE;
          stateNext = S_WAIT;
        end else begin
          stateNext = S_MARK;
        end
      end
      default: stateNext = S_WAIT;
    endcase
  end
endmodule

// File: rtl/cmd_walker.sv
module cmd_walker
  import cmd_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  input  logic [PTR_W-1:0]  startPtr,
  output logic              memReq,
  output logic              memWe,
  output logic [PTR_W-1:0]  memAddr,
  output logic [HW_W-1:0]   memWdata,
  input  logic [HW_W-1:0]   memRdata,
  input  logic              memAck,
  output logic              opValid,
  output logic [OP_W-1:0]   opCode,
  output logic [PTR_W-1:0]  opPtr,
  input  logic              opDone,
  output logic              cmdDone,
  output logic              cxFlag,
  output logic [1:0]        cuState
);
  dpCtl_t ctl;
  cuState_e cuEnum;
  logic cmdEol, cmdSusp, cmdIntr, ptrNull, startNull;

  cmd_walker_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .startNull(startNull),
    .memAck(memAck), .opDone(opDone), .cmdEol(cmdEol), .cmdSusp(cmdSusp),
    .cmdIntr(cmdIntr), .ptrNull(ptrNull), .ctl(ctl), .memReq(memReq),
    .memWe(memWe), .opValid(opValid), .cmdDone(cmdDone), .cxFlag(cxFlag),
    .cuState(cuEnum)
  );

  cmd_walker_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .startPtr(startPtr),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .curPtr(opPtr), .opCode(opCode), .cmdEol(cmdEol), .cmdSusp(cmdSusp),
    .cmdIntr(cmdIntr), .ptrNull(ptrNull), .startNull(startNull)
  );

  assign cuState = cuEnum;
endmodule

// File: rtl/cmd_walker_chk.sv
module cmd_walker_chk
  import cmd_walker_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              startValid,
  input logic [PTR_W-1:0]  startPtr,
  input logic              memReq,
  input logic              memWe,
  input logic [PTR_W-1:0]  memAddr,
  input logic [HW_W-1:0]   memWdata,
  input logic              memAck,
  input logic              opValid,
  input logic              opDone,
  input logic              cmdDone,
  input logic [1:0]        cuState
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(memReq && opValid));

  assert_op_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && !opDone |=> opValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |=> !cmdDone);

  assert_done_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |-> cuState == 2'd2);

  assert_null_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    startValid && (&startPtr) && cuState == 2'd0 |=> cuState == 2'd0 && !memReq);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cuState != 2'd3);
endmodule

bind cmd_walker cmd_walker_chk u_chk (.*);

// File: tb/cmd_walker_bench.sv
module cmd_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NULLP = 32'hFFFF_FFFF;
  localparam logic [31:0] DA = 32'h40;
  localparam logic [31:0] DB = 32'h60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic startValid = 1'b0;
  logic [31:0] startPtr = '0;
  logic memReq, memWe, opValid, cmdDone, cxFlag;
  logic [31:0] memAddr, opPtr;
  logic [15:0] memWdata, memRdata;
  logic memAck = 1'b0, opDone = 1'b0;
  logic [2:0] opCode;
  logic [1:0] cuState;

  logic [15:0] mem [256];
  int ackCnt = 0, doneCnt = 0, logCnt = 0, holdCnt = 0;
  logic [31:0] logPtr [8];
  logic [2:0]  logOp [8];
  logic [15:0] logStat [8];
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_walker u_cmd_walker (.*);

  assign memRdata = mem[memAddr[8:1]];

  always @(posedge clk) begin
    if (!rst_n) memAck <= 1'b0;
    else begin
      if (memAck) begin
        ackCnt = ackCnt + 1;
        if (memWe) mem[memAddr[8:1]] = memWdata;
      end
      memAck <= memReq && !memAck;
    end
  end

  always @(posedge clk) begin
    if (cmdDone) doneCnt = doneCnt + 1;
    if (opDone) begin
      opDone <= 1'b0;
      holdCnt = 0;
    end else if (opValid) begin
      if (holdCnt == int'(opCode)) begin
        opDone <= 1'b1;
        if (logCnt < 8) begin
          logPtr[logCnt] = opPtr;
          logOp[logCnt] = opCode;
          logStat[logCnt] = mem[opPtr[8:1]];
        end
        logCnt = logCnt + 1;
      end else holdCnt = holdCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [15:0] cmd, input logic [31:0] link);
    mem[a[8:1]] = 16'h0000;
    mem[a[8:1] + 1] = cmd;
    mem[a[8:1] + 2] = link[15:0];
    mem[a[8:1] + 3] = link[31:16];
  endtask

  task automatic pulseStart(input logic [31:0] p);
    @(negedge clk);
    startPtr = p;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic waitStop();
    for (int i = 0; i < 2000; i++) begin
      if (cuState != 2'd2) break;
      @(negedge clk);
    end
  endtask

  task automatic clearLog();
    ackCnt = 0; doneCnt = 0; logCnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cuState == 2'd0 && !cxFlag && !memReq && !opValid && !cmdDone, "R1 reset",
          {cuState, cxFlag, memReq, opValid, cmdDone}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 null head: no access, stays idle
    clearLog();
    pulseStart(NULLP);
    repeat (4) @(negedge clk);
    check(cuState == 2'd0 && ackCnt == 0, "R2 null head", {cuState, 16'(ackCnt)}, 32'h0);

    // Sweep: every opcode against every combination of the three control bits
    for (int op = 0; op < 8; op++) begin
      for (int fl = 0; fl < 8; fl++) begin
        bit eol = fl[2], susp = fl[1], intr = fl[0];
        int execN = (eol || susp) ? 1 : 2;
        int expAck = (eol ? 3 : 5) + (execN == 2 ? 5 : 0);
        putDesc(DA, {eol, susp, intr, 10'd0, 3'(op)}, DB);
        putDesc(DB, {13'd0, 3'(op + 1)}, NULLP);
        clearLog();
        pulseStart(DA);
        check(cuState == 2'd2, "R2 start makes active", cuState, 2);
        waitStop();
        check(logCnt == execN, "R6 R7 R8 descriptors run", logCnt, execN);
        check(logPtr[0] == DA && logOp[0] == 3'(op), "R4 opcode and pointer",
              {logPtr[0][15:0], 13'd0, logOp[0]}, {DA[15:0], 13'd0, 3'(op)});
        check(logStat[0] == 16'h4000, "R3 busy status during dispatch", logStat[0], 16'h4000);
        check(mem[DA[8:1]] == 16'hA000, "R5 completion status", mem[DA[8:1]], 16'hA000);
        check(mem[DB[8:1]] == (execN == 2 ? 16'hA000 : 16'h0), "R6 second descriptor status",
              mem[DB[8:1]], (execN == 2 ? 16'hA000 : 16'h0));
        check(ackCnt == expAck, "R6 R7 R10 memory transfers", ackCnt, expAck);
        check(cuState == (susp ? 2'd1 : 2'd0), "R8 final state", cuState, susp ? 1 : 0);
        check(cxFlag == (execN == 2 ? 1'b0 : intr), "R9 interrupt flag", cxFlag, execN == 2 ? 0 : intr);
        check(doneCnt == execN, "R9 completion events", doneCnt, execN);
        if (execN == 2)
          check(logPtr[1] == DB && logOp[1] == 3'(op + 1), "R7 link followed", logPtr[1], DB);
      end
    end

    // R7 null link without end-of-list bit; interrupt flag raised
    putDesc(DA, 16'h2005, NULLP);
    clearLog();
    pulseStart(DA);
    waitStop();
    check(logCnt == 1 && ackCnt == 5 && cuState == 2'd0, "R7 null link ends walk",
          {logCnt[7:0], ackCnt[7:0], 14'd0, cuState}, {8'd1, 8'd5, 16'd0});
    check(cxFlag == 1'b1, "R9 flag from interrupt bit", cxFlag, 1);

    // R2 start while active is ignored
    putDesc(DA, 16'h0007, DB);
    putDesc(DB, 16'h0006, NULLP);
    putDesc(32'h80, 16'h0001, NULLP);
    clearLog();
    pulseStart(DA);
    repeat (3) @(negedge clk);
    startPtr = 32'h80; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    waitStop();
    check(logCnt == 2 && logPtr[0] == DA && logPtr[1] == DB, "R2 start ignored while active",
          logPtr[1], DB);
    check(mem[32'h40] == 16'h0000, "R2 ignored start touched nothing", mem[32'h40], 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule